// File: doc/BRIEF.md
# Power-Management Command, SMI Gating and Reset Control Slice

This block holds four byte-wide control registers behind one small register port. A command register takes a byte from system software. Two special byte values switch an ACPI-enabled state bit on and off. Any other byte raises a system management interrupt (SMI), but only while the command-trigger enable bit of the SMI enable register is set.

A power control register carries a lock bit. Once software sets the lock, the lock bit itself can no longer be changed. From then on the global SMI enable bit also keeps its value until the next reset. A reset control register can request a system reset through a one-cycle pulse. On any write that does not request a reset, it keeps only two of the written bits.

All registers accept a write on a clock edge where `wr_en_i` is high. They read back combinationally on `rdata_o` for the register selected by `addr_i`. The address map is: 0 = command, 1 = SMI enable, 2 = power control, 3 = reset control.

Top module: `pm_ctrl_slice`

## Requirements
- R1: After reset, all four registers read 0 and `acpi_en_o`, `smi_o` and `rst_req_o` are low.
- R2: A command write of ACPI_ON_CMD (default 0x02) sets `acpi_en_o` from the next cycle on and raises no SMI pulse.
- R3: A command write of ACPI_OFF_CMD (default 0x03) clears `acpi_en_o` from the next cycle on and raises no SMI pulse.
- R4: A command write of any other value makes `smi_o` high for exactly the one cycle after the write if bit 5 of the SMI enable register is 1. If that bit is 0, `smi_o` stays low. `acpi_en_o` is not changed.
- R5: The command register reads back the last byte written to it.
- R6: While the lock is clear, every bit of the SMI enable register and of the power control register reads back exactly as written.
- R7: Writing bit 4 of the power control register as 1 sets the lock. After that, bit 4 reads 1 whatever is written, until reset. The other bits of that register stay writable.
- R8: While the lock is set, bit 0 of the SMI enable register keeps its value across writes, and bits 7..1 stay writable.
- R9: A reset control write with bit 2 set makes `rst_req_o` high for exactly the one cycle after the write and leaves the stored reset control value unchanged.
- R10: A reset control write with bit 2 clear stores written bits 3 and 1. All other bits read 0, and `rst_req_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 2 | Register select (0 command, 1 SMI enable, 2 power control, 3 reset control) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| acpi_en_o | output | 1 | ACPI-enabled state |
| smi_o | output | 1 | SMI pulse, one cycle |
| rst_req_o | output | 1 | System reset request pulse, one cycle |

## Verification
A wrong command decode shows up in the very next cycle: `smi_o` fires on an ACPI command, fails to fire on an ordinary one, or `acpi_en_o` moves the wrong way. A lock that decays or a global enable that keeps changing under the lock is only visible on a later read. For this reason the bench reads back after every write in its sweeps. A reset control value corrupted by a reset-request write shows up on the read that directly follows that write.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_CMD    = 2'd0,
    REG_SMIEN  = 2'd1,
    REG_PWRCTL = 2'd2,
    REG_RSTCTL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/apm_cmd_port.sv
module apm_cmd_port #(
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  ON_CMD  = 8'h02,
  parameter logic [7:0]  OFF_CMD = 8'h03
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              trig_en_i,
  output logic [DATA_W-1:0] cmd_o,
  output logic              acpi_en_o,
  output logic              smi_o
);
  logic is_on, is_off;
  assign is_on  = (data_i == DATA_W'(ON_CMD));
  assign is_off = (data_i == DATA_W'(OFF_CMD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o     <= '0;
      acpi_en_o <= 1'b0;
      smi_o     <= 1'b0;
    end else begin
      smi_o <= wr_i && !is_on && !is_off && trig_en_i;
      if (wr_i) begin
        cmd_o <= data_i;
        if (is_on)       acpi_en_o <= 1'b1;
        else if (is_off) acpi_en_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs #(
  parameter int DATA_W   = 8,
  parameter int GBL_BIT  = 0,
  parameter int LOCK_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_smien_i,
  input  logic              wr_pwr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] smi_en_o,
  output logic [DATA_W-1:0] pwr_ctl_o,
  output logic              lock_o
);
  assign lock_o = pwr_ctl_o[LOCK_BIT];

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    // SMI enable: only the global bit honours the lock
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        smi_en_o[b] <= 1'b0;
      else if (wr_smien_i && !((b == GBL_BIT) && lock_o))
        smi_en_o[b] <= data_i[b];
    end
    // Power control: lock bit is sticky once set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        pwr_ctl_o[b] <= 1'b0;
      else if (wr_pwr_i && !((b == LOCK_BIT) && lock_o))
        pwr_ctl_o[b] <= data_i[b];
    end
  end
endmodule

// File: rtl/rst_ctrl_port.sv
module rst_ctrl_port #(
  parameter int          DATA_W    = 8,
  parameter int          REQ_BIT   = 2,
  parameter logic [7:0]  KEEP_MASK = 8'h0A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] val_o,
  output logic              req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_o <= '0;
      req_o <= 1'b0;
    end else begin
      req_o <= wr_i && data_i[REQ_BIT];
      if (wr_i && !data_i[REQ_BIT])
        val_o <= data_i & DATA_W'(KEEP_MASK);
    end
  end
endmodule

// File: rtl/pm_ctrl_slice.sv
module pm_ctrl_slice #(
  parameter int          DATA_W       = 8,
  parameter logic [7:0]  ACPI_ON_CMD  = 8'h02,
  parameter logic [7:0]  ACPI_OFF_CMD = 8'h03,
  parameter int          TRIG_EN_BIT  = 5,
  parameter int          GBL_BIT      = 0,
  parameter int          LOCK_BIT     = 4,
  parameter int          RST_REQ_BIT  = 2,
  parameter logic [7:0]  RST_KEEP     = 8'h0A
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [pm_pkg::ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      acpi_en_o,
  output logic                      smi_o,
  output logic                      rst_req_o
);
  import pm_pkg::*;

  reg_sel_e          sel;
  logic [DATA_W-1:0] cmd_q, smi_en_q, pwr_q, rst_q;
  logic              lock_q;

  assign sel = reg_sel_e'(addr_i);

  apm_cmd_port #(.DATA_W(DATA_W), .ON_CMD(ACPI_ON_CMD), .OFF_CMD(ACPI_OFF_CMD)) u_cmd (
    .clk_i, .rst_ni,
    .wr_i      (wr_en_i && sel == REG_CMD),
    .data_i    (wdata_i),
    .trig_en_i (smi_en_q[TRIG_EN_BIT]),
    .cmd_o     (cmd_q),
    .acpi_en_o (acpi_en_o),
    .smi_o     (smi_o)
  );

  smi_cfg_regs #(.DATA_W(DATA_W), .GBL_BIT(GBL_BIT), .LOCK_BIT(LOCK_BIT)) u_cfg (
    .clk_i, .rst_ni,
    .wr_smien_i (wr_en_i && sel == REG_SMIEN),
    .wr_pwr_i   (wr_en_i && sel == REG_PWRCTL),
    .data_i     (wdata_i),
    .smi_en_o   (smi_en_q),
    .pwr_ctl_o  (pwr_q),
    .lock_o     (lock_q)
  );

  rst_ctrl_port #(.DATA_W(DATA_W), .REQ_BIT(RST_REQ_BIT), .KEEP_MASK(RST_KEEP)) u_rst (
    .clk_i, .rst_ni,
    .wr_i   (wr_en_i && sel == REG_RSTCTL),
    .data_i (wdata_i),
    .val_o  (rst_q),
    .req_o  (rst_req_o)
  );

  always_comb begin
    unique case (sel)
      REG_CMD:    rdata_o = cmd_q;
      REG_SMIEN:  rdata_o = smi_en_q;
      REG_PWRCTL: rdata_o = pwr_q;
      default:    rdata_o = rst_q;
    endcase
  end
endmodule

// File: rtl/pm_ctrl_slice_chk.sv
module pm_ctrl_slice_chk #(
  parameter int         DATA_W       = 8,
  parameter logic [7:0] ACPI_ON_CMD  = 8'h02,
  parameter logic [7:0] ACPI_OFF_CMD = 8'h03,
  parameter int         GBL_BIT      = 0,
  parameter int         RST_REQ_BIT  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              acpi_en_o,
  input logic              smi_o,
  input logic              rst_req_o,
  input logic              lock_q,
  input logic [DATA_W-1:0] smi_en_q,
  input logic [DATA_W-1:0] rst_q
);
  logic cmd_wr, rst_wr;
  assign cmd_wr = wr_en_i && addr_i == 2'd0;
  assign rst_wr = wr_en_i && addr_i == 2'd3;

  AST_ACPI_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && wdata_i == DATA_W'(ACPI_ON_CMD) |=> acpi_en_o && !smi_o); // R2
  AST_ACPI_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && wdata_i == DATA_W'(ACPI_OFF_CMD) |=> !acpi_en_o && !smi_o); // R3
  AST_SMI_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smi_o) |-> $past(cmd_wr)); // R4
  AST_SMI_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o && !cmd_wr |=> !smi_o); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R7
  AST_GBL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> smi_en_q[GBL_BIT] == $past(smi_en_q[GBL_BIT])); // R8
  AST_RST_REQ_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_wr && wdata_i[RST_REQ_BIT] |=> rst_req_o && $stable(rst_q)); // R9
  AST_RST_REQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(rst_wr && wdata_i[RST_REQ_BIT])); // R9
endmodule

bind pm_ctrl_slice pm_ctrl_slice_chk #(
  .DATA_W(DATA_W), .ACPI_ON_CMD(ACPI_ON_CMD), .ACPI_OFF_CMD(ACPI_OFF_CMD),
  .GBL_BIT(GBL_BIT), .RST_REQ_BIT(RST_REQ_BIT)
) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
  .acpi_en_o, .smi_o, .rst_req_o,
  .lock_q, .smi_en_q, .rst_q
);

// File: tb/pm_ctrl_slice_test.sv
module pm_ctrl_slice_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       acpi_en, smi, rst_req;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  pm_ctrl_slice uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .acpi_en_o(acpi_en), .smi_o(smi), .rst_req_o(rst_req)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write, then sample pulses in the cycle after the write
  task automatic wr(input logic [1:0] a, input logic [7:0] d,
                    output logic p_smi, output logic p_rst);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    p_smi = smi; p_rst = rst_req;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; #1;
    d = rdata;
  endtask

  initial begin
    logic [7:0] r, smien_m, rst_m;
    logic ps, pr, acpi_m;
    #22 rst_n = 1'b1;
    #1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R1 reg", r, 0);
    end
    chk("R1 acpi", acpi_en, 0);
    chk("R1 smi", smi, 0);
    chk("R1 rst_req", rst_req, 0);

    // R2-R5 command sweep with trigger enable off, then on
    acpi_m = 1'b0;
    for (int en = 0; en < 2; en++) begin
      wr(2'd1, en ? 8'h20 : 8'h00, ps, pr);
      for (int v = 0; v < 256; v++) begin
        wr(2'd0, 8'(v), ps, pr);
        if (v == 2) acpi_m = 1'b1;
        else if (v == 3) acpi_m = 1'b0;
        chk((v == 2) ? "R2 smi" : (v == 3) ? "R3 smi" : "R4 smi",
            ps, (en == 1 && v != 2 && v != 3) ? 1 : 0);
        chk("R4 acpi", acpi_en, acpi_m);
        @(posedge clk); #1;
        chk("R4 pulse width", smi, 0);
        rd(2'd0, r);
        chk("R5 cmd readback", r, v);
      end
    end
    wr(2'd0, 8'h02, ps, pr);
    chk("R2 acpi on", acpi_en, 1);
    wr(2'd0, 8'h03, ps, pr);
    chk("R3 acpi off", acpi_en, 0);

    // R6 unlocked readback of SMI enable and power control
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 8'(v), ps, pr);
      rd(2'd1, r);
      chk("R6 smien", r, v);
      if (v[4] == 1'b0) begin
        wr(2'd2, 8'(v), ps, pr);
        rd(2'd2, r);
        chk("R6 pwrctl", r, v);
      end
    end
    wr(2'd1, 8'h01, ps, pr);
    smien_m = 8'h01;

    // R7 set lock, then try to clear it
    wr(2'd2, 8'h10, ps, pr);
    for (int v = 0; v < 256; v++) begin
      wr(2'd2, 8'(v), ps, pr);
      rd(2'd2, r);
      chk("R7 lock sticky", r, v | 8'h10);
    end

    // R8 global bit frozen under lock
    for (int v = 0; v < 256; v++) begin
      wr(2'd1, 8'(v), ps, pr);
      smien_m = (8'(v) & 8'hFE) | (smien_m & 8'h01);
      rd(2'd1, r);
      chk("R8 smien locked", r, smien_m);
    end

    // R9/R10 reset control sweep
    rst_m = 8'h00;
    for (int v = 0; v < 256; v++) begin
      wr(2'd3, 8'(v), ps, pr);
      if (v[2] == 1'b0) rst_m = 8'(v) & 8'h0A;
      chk(v[2] ? "R9 rst_req" : "R10 rst_req", pr, v[2]);
      @(posedge clk); #1;
      chk("R9 pulse width", rst_req, 0);
      rd(2'd3, r);
      chk(v[2] ? "R9 rstctl kept" : "R10 rstctl stored", r, rst_m);
    end

    // R1 reset again clears lock and all state
    @(negedge clk); rst_n = 1'b0;
    #7 rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), r);
      chk("R1 after reset", r, 0);
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule